// File: doc/BRIEF.md
# Memory power-up configuration sequencer

This block sits in front of a dword-oriented controller for an 8-bit DDR pseudo-static RAM and brings the memory into a usable state after reset. It first counts out the memory's 150 µs power-on interval, using a count derived from the clock frequency parameter. It then optionally reads an identification register to confirm the device, and optionally writes a configuration register that moves the device to 3-clock latency. The latency settings it drives to the controller follow the device state: the default 6-clock values until the latency-shortening write has completed, the short values after it.

While the sequence runs, user read and write requests are held off the controller and the block drives the controller request ports itself. Each request is a single-cycle pulse, raised only while the controller reports idle. After each request the block waits for the controller's busy flag to rise and then to fall before it moves to the next step. When the sequence ends, `ready` rises and stays high, and from then on every user request field passes straight through to the controller.

Top module: `psram_pwrup_seq`

## Requirements
- R1: The wait length is W = ceil(CLK_HZ × POR_US / 1e6) cycles. No controller request appears before W clock edges have passed since reset release. When the controller is idle, the first request is presented in the cycle after edge W+1.
- R2: With CHECK_ID set, the first step is an identification read. It is a one-cycle `ctl_rd_req` pulse with `ctl_reg_sel`=1 and `ctl_addr`=0x00000000.
- R3: The identification read passes when bits [31:16] of the returned dword equal 0x0c81. On any other value `id_error` goes high and stays high until reset. The sequence still carries on to completion.
- R4: With CONFIGURE set, the block issues one configuration write. It is a one-cycle `ctl_wr_req` pulse with `ctl_reg_sel`=1, `ctl_addr`=0x00000800, `ctl_wr_data`=0x8fe40000 and `ctl_byte_en`=0xF.
- R5: The read comes before the write. The next request, or the end of the sequence, waits until busy has been seen high and then low again. For the read, it also waits for `ctl_rd_valid`.
- R6: `lat_short`/`lat_long` are 0x12/0x16 until the configuration write has completed, and 0x04/0x0a after that. With CONFIGURE clear they stay 0x12/0x16.
- R7: `ready` stays low until the last step completes, then stays high until reset. With both options clear, `ready` is first seen high after exactly W edges.
- R8: While `ready` is low, user read and write requests never reach the controller. While `ready` is high, all user request fields appear on the controller ports unchanged in the same cycle.
- R9: A request is never raised while `ctl_busy` is high. If busy is held high when a step is due, the request follows in the cycle after busy has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usr_rd_req | input | 1 | User read request pulse |
| usr_wr_req | input | 1 | User write request pulse |
| usr_reg_sel | input | 1 | User memory (0) or register (1) select |
| usr_byte_en | input | 4 | User write byte enables |
| usr_addr | input | 32 | User byte address |
| usr_wr_data | input | 32 | User write data |
| ctl_busy | input | 1 | Controller busy flag |
| ctl_rd_valid | input | 1 | Controller read-data strobe |
| ctl_rd_data | input | 32 | Controller read data |
| ctl_rd_req | output | 1 | Read request to controller |
| ctl_wr_req | output | 1 | Write request to controller |
| ctl_reg_sel | output | 1 | Memory/register select to controller |
| ctl_byte_en | output | 4 | Byte enables to controller |
| ctl_addr | output | 32 | Address to controller |
| ctl_wr_data | output | 32 | Write data to controller |
| lat_short | output | 8 | Single-latency setting for controller |
| lat_long | output | 8 | Double-latency setting for controller |
| ready | output | 1 | Sequence complete |
| id_error | output | 1 | Identification mismatch, sticky |

## Verification
The assertions assume that the controller raises busy in the cycle after it accepts a request. They also assume that a read's data strobe arrives only after busy has risen, and that busy returns low in the end. The bench's controller model keeps to this: each accepted request produces four busy cycles, with the read strobe in the last of them. It can also hold busy high on its own around the moment the first request is due, which exercises the wait on an idle controller. User request pulses are applied both before and after `ready` rises, so the gating and the pass-through are both seen at the controller ports.

// File: rtl/psram_pwrup_seq.sv
module psram_pwrup_seq #(
  parameter longint CLK_HZ    = 100_000_000,
  parameter int     POR_US    = 150,
  parameter bit     CONFIGURE = 1'b1,
  parameter bit     CHECK_ID  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        usr_rd_req,
  input  logic        usr_wr_req,
  input  logic        usr_reg_sel,
  input  logic [3:0]  usr_byte_en,
  input  logic [31:0] usr_addr,
  input  logic [31:0] usr_wr_data,
  input  logic        ctl_busy,
  input  logic        ctl_rd_valid,
  input  logic [31:0] ctl_rd_data,
  output logic        ctl_rd_req,
  output logic        ctl_wr_req,
  output logic        ctl_reg_sel,
  output logic [3:0]  ctl_byte_en,
  output logic [31:0] ctl_addr,
  output logic [31:0] ctl_wr_data,
  output logic [7:0]  lat_short,
  output logic [7:0]  lat_long,
  output logic        ready,
  output logic        id_error
);
  localparam longint WAIT_LL  = (CLK_HZ * longint'(POR_US) + 64'd999_999) / 64'd1_000_000;
  localparam int     WAIT_CYC = int'(WAIT_LL);
  localparam int     CW       = $clog2(WAIT_CYC + 1);
  localparam logic [31:0] ID_ADDR  = 32'h0000_0000;
  localparam logic [31:0] CFG_ADDR = 32'h0000_0800;
  localparam logic [31:0] CFG_DATA = 32'h8fe4_0000;
  localparam logic [15:0] ID_VAL   = 16'h0c81;

  typedef enum logic [2:0] {S_POR, S_ISSUE, S_RISE, S_VAL, S_FALL, S_DONE} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        req_q, step_rd, lat_cfg;
  logic        unused_lo;

  assign unused_lo = ^ctl_rd_data[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_POR;
      cnt      <= '0;
      req_q    <= 1'b0;
      step_rd  <= 1'b0;
      lat_cfg  <= 1'b0;
      id_error <= 1'b0;
    end else begin
      req_q <= 1'b0;
      case (st)
        S_POR:
          if (cnt == CW'(WAIT_CYC - 1)) begin
            if (CHECK_ID) begin
              step_rd <= 1'b1;
              st      <= S_ISSUE;
            end else if (CONFIGURE) begin
              step_rd <= 1'b0;
              st      <= S_ISSUE;
            end else begin
              st <= S_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_ISSUE:
          if (!ctl_busy) begin
            req_q <= 1'b1;
            st    <= S_RISE;
          end
        S_RISE:
          if (ctl_busy) st <= step_rd ? S_VAL : S_FALL;
        S_VAL:
          if (ctl_rd_valid) begin
            if (ctl_rd_data[31:16] != ID_VAL) id_error <= 1'b1;
            st <= S_FALL;
          end
        S_FALL:
          if (!ctl_busy) begin
            if (step_rd && CONFIGURE) begin
              step_rd <= 1'b0;
              st      <= S_ISSUE;
            end else begin
              if (!step_rd) lat_cfg <= 1'b1;
              st <= S_DONE;
            end
          end
        default: st <= S_DONE;
      endcase
    end
  end

  assign ready       = (st == S_DONE);
  assign ctl_rd_req  = ready ? usr_rd_req  : (req_q & step_rd);
  assign ctl_wr_req  = ready ? usr_wr_req  : (req_q & ~step_rd);
  assign ctl_reg_sel = ready ? usr_reg_sel : 1'b1;
  assign ctl_byte_en = ready ? usr_byte_en : 4'hF;
  assign ctl_addr    = ready ? usr_addr    : (step_rd ? ID_ADDR : CFG_ADDR);
  assign ctl_wr_data = ready ? usr_wr_data : CFG_DATA;
  assign lat_short   = lat_cfg ? 8'h04 : 8'h12;
  assign lat_long    = lat_cfg ? 8'h0a : 8'h16;
endmodule

// File: rtl/psram_pwrup_seq_chk.sv
module psram_pwrup_seq_chk #(
  parameter int WAIT_CYC = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        ready,
  input logic        ctl_busy,
  input logic        ctl_rd_req,
  input logic        ctl_wr_req,
  input logic        ctl_reg_sel,
  input logic [3:0]  ctl_byte_en,
  input logic [31:0] ctl_addr,
  input logic [31:0] ctl_wr_data,
  input logic [7:0]  lat_short,
  input logic [7:0]  lat_long,
  input logic        id_error
);
  int cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else if (cyc < WAIT_CYC) cyc <= cyc + 1;
  end

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc < WAIT_CYC) |-> !(ctl_rd_req || ctl_wr_req));

  // R2
  id_read_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && ctl_rd_req) |-> (ctl_reg_sel && ctl_addr == 32'h0));

  // R3
  id_error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    id_error |=> id_error);

  // R4
  cfg_write_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && ctl_wr_req) |-> (ctl_reg_sel && ctl_addr == 32'h800 &&
                                ctl_wr_data == 32'h8fe40000 && ctl_byte_en == 4'hF));

  // R4
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && ctl_wr_req) |=> !ctl_wr_req);

  // R6
  lat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ($stable(lat_short) && $stable(lat_long)));

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R9
  idle_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && (ctl_rd_req || ctl_wr_req)) |-> !ctl_busy);
endmodule

bind psram_pwrup_seq psram_pwrup_seq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .ctl_busy(ctl_busy),
  .ctl_rd_req(ctl_rd_req), .ctl_wr_req(ctl_wr_req), .ctl_reg_sel(ctl_reg_sel),
  .ctl_byte_en(ctl_byte_en), .ctl_addr(ctl_addr), .ctl_wr_data(ctl_wr_data),
  .lat_short(lat_short), .lat_long(lat_long), .id_error(id_error)
);

// File: tb/tb_psram_pwrup_seq.sv
module tb_psram_pwrup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W_A = 32; // ceil(150 us * 0.21 MHz) = ceil(31.5)
  localparam int W_B = 30; // 150 us * 0.2 MHz

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        u_rd = 0, u_wr = 0, u_rs = 0;
  logic [3:0]  u_be = 0;
  logic [31:0] u_addr = 0, u_wd = 0;

  logic        busy, rvalid;
  logic [31:0] rdata;
  logic        c_rd, c_wr, c_rs, rdy, err;
  logic [3:0]  c_be;
  logic [31:0] c_addr, c_wd;
  logic [7:0]  l1, l2;

  logic        b_rd, b_wr, b_rs, b_rdy, b_err;
  logic [3:0]  b_be;
  logic [31:0] b_addr, b_wd;
  logic [7:0]  b_l1, b_l2;

  psram_pwrup_seq #(.CLK_HZ(210_000)) dut (
    .clk(clk), .rst(rst), .usr_rd_req(u_rd), .usr_wr_req(u_wr), .usr_reg_sel(u_rs),
    .usr_byte_en(u_be), .usr_addr(u_addr), .usr_wr_data(u_wd),
    .ctl_busy(busy), .ctl_rd_valid(rvalid), .ctl_rd_data(rdata),
    .ctl_rd_req(c_rd), .ctl_wr_req(c_wr), .ctl_reg_sel(c_rs), .ctl_byte_en(c_be),
    .ctl_addr(c_addr), .ctl_wr_data(c_wd), .lat_short(l1), .lat_long(l2),
    .ready(rdy), .id_error(err));

  psram_pwrup_seq #(.CLK_HZ(200_000), .CONFIGURE(1'b0), .CHECK_ID(1'b0)) dut_b (
    .clk(clk), .rst(rst), .usr_rd_req(u_rd), .usr_wr_req(u_wr), .usr_reg_sel(u_rs),
    .usr_byte_en(u_be), .usr_addr(u_addr), .usr_wr_data(u_wd),
    .ctl_busy(1'b0), .ctl_rd_valid(1'b0), .ctl_rd_data(32'h0),
    .ctl_rd_req(b_rd), .ctl_wr_req(b_wr), .ctl_reg_sel(b_rs), .ctl_byte_en(b_be),
    .ctl_addr(b_addr), .ctl_wr_data(b_wd), .lat_short(b_l1), .lat_long(b_l2),
    .ready(b_rdy), .id_error(b_err));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // controller model
  int          cyc = 0, bcnt = 0;
  bit          last_rd = 0, hold_en = 0;
  logic [15:0] id_val = 16'h0c81;
  bit          q_rd[$];
  logic [31:0] q_addr[$], q_wd[$];
  logic [3:0]  q_be[$];
  logic        q_rs[$];
  int          q_cyc[$];
  wire hold = hold_en && cyc >= W_A - 3 && cyc <= W_A + 6;
  assign busy = (bcnt != 0) || hold;

  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (rst) begin
      cyc <= 0; bcnt <= 0; rdata <= 32'h0;
    end else begin
      cyc <= cyc + 1;
      if (bcnt == 0 && !hold && (c_rd || c_wr)) begin
        bcnt <= 4;
        last_rd <= c_rd;
        if (!rdy) begin
          q_rd.push_back(c_rd); q_addr.push_back(c_addr); q_wd.push_back(c_wd);
          q_be.push_back(c_be); q_rs.push_back(c_rs); q_cyc.push_back(cyc);
        end
      end else if (bcnt > 0) begin
        bcnt <= bcnt - 1;
        if (bcnt == 2 && last_rd) begin
          rvalid <= 1'b1;
          rdata  <= {id_val, 16'h5a5a};
        end
      end
    end
  end

  // cycle-by-cycle reference model of the sequence, checked at each negedge
  int m_ph = 0, m_cnt = 0;
  bit m_rd = 0, m_lat = 0, m_req = 0, m_err = 0;
  always @(negedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_rd = 0; m_lat = 0; m_req = 0; m_err = 0;
    end else begin
      chk(rdy == (m_ph == 5), "R7", "ready", rdy, m_ph == 5);
      chk(l1 == (m_lat ? 8'h04 : 8'h12), "R6", "lat_short", l1, m_lat ? 8'h04 : 8'h12);
      chk(l2 == (m_lat ? 8'h0a : 8'h16), "R6", "lat_long", l2, m_lat ? 8'h0a : 8'h16);
      chk(err == m_err, "R3", "id_error", err, m_err);
      if (m_ph != 5) begin
        chk(c_rd == (m_req && m_rd), "R8", "gated rd_req", c_rd, m_req && m_rd);
        chk(c_wr == (m_req && !m_rd), "R8", "gated wr_req", c_wr, m_req && !m_rd);
      end
      chk(b_rdy == (cyc >= W_B), "R7", "ready no-option", b_rdy, cyc >= W_B);
      chk(b_l1 == 8'h12 && b_l2 == 8'h16, "R6", "latency no-option", {b_l1, b_l2}, 16'h1216);
      if (!b_rdy) chk(!b_rd && !b_wr, "R8", "no-option request", {b_rd, b_wr}, 0);
      m_req = 0;
      case (m_ph)
        0: if (m_cnt == W_A - 1) begin m_ph = 1; m_rd = 1; end else m_cnt++;
        1: if (!busy) begin m_req = 1; m_ph = 2; end
        2: if (busy) m_ph = m_rd ? 3 : 4;
        3: if (rvalid) begin
             if (rdata[31:16] != 16'h0c81) m_err = 1;
             m_ph = 4;
           end
        4: if (!busy) begin
             if (m_rd) begin m_rd = 0; m_ph = 1; end
             else begin m_lat = 1; m_ph = 5; end
           end
        default: ;
      endcase
    end
  end

  task automatic step;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic run_seq(input int first_cyc, input string tag);
    rst = 1'b1;
    q_rd.delete(); q_addr.delete(); q_wd.delete(); q_be.delete(); q_rs.delete(); q_cyc.delete();
    repeat (3) step();
    rst = 1'b0;
    for (int i = 0; i < 400 && !rdy; i++) begin
      u_rd = (i % 7 == 3); u_wr = (i % 5 == 1); u_rs = 1'b0;
      u_be = 4'h3; u_addr = 32'h1000 + i; u_wd = 32'hdead0000 + i;
      step();
    end
    u_rd = 0; u_wr = 0;
    chk(rdy, "R7", "ready reached", rdy, 1);
    chk(q_rd.size() == 2, "R5", "request count", q_rd.size(), 2);
    if (q_rd.size() == 2) begin
      chk(q_rd[0] == 1 && q_rd[1] == 0, "R5", "read then write", {q_rd[0], q_rd[1]}, 2'b10);
      chk(q_addr[0] == 32'h0 && q_rs[0], "R2", "id read addr/sel", q_addr[0], 0);
      chk(q_addr[1] == 32'h800 && q_rs[1], "R4", "cfg addr/sel", q_addr[1], 32'h800);
      chk(q_wd[1] == 32'h8fe40000, "R4", "cfg data", q_wd[1], 32'h8fe40000);
      chk(q_be[1] == 4'hF, "R4", "cfg byte enables", q_be[1], 4'hF);
      chk(q_cyc[0] == first_cyc, tag, "first request cycle", q_cyc[0], first_cyc);
    end
  endtask

  initial begin
    // run 1: matching identity, idle controller
    run_seq(W_A + 1, "R1");
    chk(err == 0, "R3", "no id error", err, 0);
    chk(l1 == 8'h04 && l2 == 8'h0a, "R6", "short latency", {l1, l2}, 16'h040a);
    // pass-through after ready
    for (int i = 0; i < 6; i++) begin
      u_rd = i[0]; u_wr = !i[0]; u_rs = i[1]; u_be = 4'(i + 5);
      u_addr = 32'h00abc000 ^ i; u_wd = 32'h13570000 + i;
      #1;
      chk(c_rd == u_rd && c_wr == u_wr && c_rs == u_rs, "R8", "pass-through ctrl",
          {c_rd, c_wr, c_rs}, {u_rd, u_wr, u_rs});
      chk(c_addr == u_addr && c_wd == u_wd && c_be == u_be, "R8", "pass-through data",
          c_addr, u_addr);
      step();
    end
    u_rd = 0; u_wr = 0;
    repeat (8) step();
    // run 2: wrong identity, controller busy when the first step is due
    id_val = 16'h1234;
    hold_en = 1;
    run_seq(W_A + 8, "R9");
    chk(err == 1, "R3", "id mismatch flagged", err, 1);
    chk(l1 == 8'h04, "R3", "sequence continued after mismatch", l1, 8'h04);
    repeat (5) step();
    chk(err == 1 && rdy == 1, "R3", "error and ready held", {err, rdy}, 2'b11);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule